// File: doc/BRIEF.md
# NAND Flash Discovery Sequencer

This block runs once each time reset is released. It works out what kind of NAND device is attached and leaves it in a usable state. It samples five configuration straps, waits for the device to report ready, and then sends a Read ID probe. The probe reply decides which identification path it takes. A device that answers the probe with a valid ONFI signature has its parameter page read, and the feature byte from that page is kept. Any other device is treated as legacy: it gets a reset, and its five ID bytes are read and kept.

After identification the sequencer issues a reset to the device and fixes the bus width at 8 or 16 bits. Unless a strap forbids it, it then loads block 0 page 0 so the host can read that page straight away. It always ends with a final reset command, after which it raises a completion flag. Every wait on the ready/busy line has a cycle limit. When a wait runs past that limit, a sticky error flag is set and the sequencer goes straight to the final reset and completion steps.

All device traffic passes through a simple byte handshake to a lower bus engine. Each request carries one command byte, one address byte, or one read slot, and the engine acknowledges it. Pin timing is handled entirely by the lower engine.

Top module: `nand_discovery_seq`

## Requirements
- R1: The five straps are captured on the first clock edge after reset is released. The path decision in that cycle uses the same values. Any strap change after that edge has no effect on the sequence or the results.
- R2: With the no-init strap set, the only traffic is a single reset command (0xFF) followed by its wait. Completion follows. No probe and no preload are issued, and dev_onfi, dev_x16, dev_id and onfi_feat stay 0.
- R3: No bus request is issued before rb_ready (1 = ready) has been seen high after reset. The exception is the no-init case.
- R4: The ONFI probe is command 0x90, address 0x20, then four reads. When those four bytes are 0x4F 0x4E 0x46 0x49 in that order, the sequencer issues command 0xEC and address 0x00, waits for ready, and reads seven bytes. Byte 6 goes to onfi_feat, and dev_onfi goes to 1.
- R5: When the probe does not match, the legacy path issues 0xFF and waits for ready. It then issues 0x90, address 0x00, and five reads. Read k is stored in dev_id bits [8k+7:8k].
- R6: With the small-page strap set, the probe is skipped and the legacy path starts directly.
- R7: After either identification path, the sequencer issues 0xFF and waits for ready. dev_x16 is set to 1 when any of these holds: the small-page x16 strap is set; the device is ONFI and onfi_feat bit 0 is 1; the device is legacy and dev_id bit 38 (ID byte 4, bit 6) is 1.
- R8: Unless the no-preload strap is set, the sequencer issues command 0x00 and then a run of 0x00 address bytes. The run holds column cycles (1 for small-page, 2 otherwise) plus row cycles (2 with the two-row strap, 3 otherwise). Command 0x30 and a ready wait follow.
- R9: The last traffic is always 0xFF and a ready wait. After that, init_done rises and stays high with no further requests.
- R10: A ready wait that lasts TMO_CYCLES cycles sets tmo_err, which stays set. The sequencer then jumps to the final 0xFF. A timeout during the final wait still ends in completion.
- R11: bus_op encodes 0 = command, 1 = address, 2 = read. While bus_req is high and bus_ack is low, bus_op and bus_wdata hold steady. Each acknowledged request moves the sequence on by exactly one byte.
- R12: During reset, bus_req, init_done, tmo_err, dev_onfi and dev_x16 are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_no_init | input | 1 | Skip the device query and the preload |
| strap_small_pg | input | 1 | 512-byte-page device; skip the ONFI probe |
| strap_small_x16 | input | 1 | Force the 16-bit bus width |
| strap_row2 | input | 1 | Two row address cycles instead of three |
| strap_no_preload | input | 1 | Skip the block 0 page 0 load |
| rb_ready | input | 1 | Device ready (1) or busy (0) |
| bus_req | output | 1 | Byte request to the bus engine |
| bus_op | output | 2 | 0 command, 1 address, 2 read |
| bus_wdata | output | 8 | Command or address byte |
| bus_ack | input | 1 | Engine accepts the current request |
| bus_rdata | input | 8 | Read byte, valid with bus_ack on a read |
| init_done | output | 1 | Sequence complete |
| tmo_err | output | 1 | A ready wait timed out (sticky) |
| dev_onfi | output | 1 | Device identified through ONFI |
| dev_x16 | output | 1 | 16-bit device bus |
| dev_id | output | 8*ID_BYTES | Legacy ID bytes, byte 0 lowest |
| onfi_feat | output | 8 | Parameter-page feature byte |

## Verification
The bench builds the block with TMO_CYCLES set to 40 and keeps the default ID_BYTES of 5 and PP_BYTES of 7. The device model's busy times are 6 and 12 cycles, well under the limit, so normal runs never time out. A device held busy forever, or one that stalls after the parameter-page command, hits both the mid-sequence timeout and the final-wait timeout within a few hundred cycles. The bench alternates between an engine that acknowledges at once and one that acknowledges every other cycle, so the hold rule is exercised under real stalls. Every table row flips all straps right after the capture edge.

// File: rtl/nds_pkg.sv
package nds_pkg;

   typedef enum logic [1:0] {
      OP_CMD  = 2'd0,
      OP_ADDR = 2'd1,
      OP_READ = 2'd2
   } bus_op_e;

   localparam logic [7:0] CMD_RESET  = 8'hFF;
   localparam logic [7:0] CMD_READID = 8'h90;
   localparam logic [7:0] CMD_PARAM  = 8'hEC;
   localparam logic [7:0] CMD_PGRD1  = 8'h00;
   localparam logic [7:0] CMD_PGRD2  = 8'h30;
   localparam logic [7:0] ADR_PROBE  = 8'h20;
   localparam logic [7:0] ADR_ZERO   = 8'h00;

   typedef struct packed {
      logic no_init;
      logic small_pg;
      logic small_x16;
      logic row2;
      logic no_preload;
   } straps_t;

   localparam straps_t STRAP_RESET_VAL = 5'b00001;

   typedef enum logic [4:0] {
      ST_STRAP, ST_RB0,
      ST_PID_C, ST_PID_A, ST_PID_R, ST_PID_D,
      ST_PP_C, ST_PP_A, ST_PP_W, ST_PP_R,
      ST_LR_C, ST_LR_W, ST_LI_C, ST_LI_A, ST_LI_R,
      ST_WR_C, ST_WR_W,
      ST_PL_C0, ST_PL_A, ST_PL_C1, ST_PL_W,
      ST_FR_C, ST_FR_W, ST_DONE
   } seq_state_e;

   function automatic logic [7:0] sig_byte(input logic [1:0] i);
      case (i)
         2'd0:    return 8'h4F;
         2'd1:    return 8'h4E;
         2'd2:    return 8'h46;
         default: return 8'h49;
      endcase
   endfunction

endpackage

// File: rtl/nds_strap_latch.sv
module nds_strap_latch
   import nds_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     capture,
   input  straps_t  raw,
   output straps_t  q
);

   always_ff @(posedge clk) begin
      if (!rst_n)       q <= STRAP_RESET_VAL;
      else if (capture) q <= raw;
   end

   // R1
   strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !capture |=> $stable(q));

endmodule

// File: rtl/nds_rb_timer.sv
module nds_rb_timer #(
   parameter int TMO_CYCLES = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic rb_ready,
   output logic ok,
   output logic expired
);

   localparam int CNT_W = (TMO_CYCLES > 1) ? $clog2(TMO_CYCLES) : 1;

   if (TMO_CYCLES < 1) begin : g_bad_tmo
      $error("nds_rb_timer: TMO_CYCLES must be at least 1");
   end

   assign ok = en && rb_ready;

   if (TMO_CYCLES == 1) begin : g_single
      assign expired = en && !rb_ready;
   end else begin : g_count
      localparam logic [CNT_W-1:0] LAST = CNT_W'(TMO_CYCLES - 1);
      logic [CNT_W-1:0] cnt;

      always_ff @(posedge clk) begin
         if (!rst_n)                cnt <= '0;
         else if (!en || rb_ready)  cnt <= '0;
         else if (cnt != LAST)      cnt <= cnt + 1'b1;
      end

      assign expired = en && !rb_ready && (cnt == LAST);

      // R10
      tmo_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (en && !rb_ready && !expired) |=> (cnt != '0) || !en);
   end

endmodule

// File: rtl/nds_capture.sv
module nds_capture
   import nds_pkg::*;
#(
   parameter int ID_BYTES = 5,
   parameter int PP_BYTES = 7,
   parameter int IDX_W    = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  take,
   input  logic                  sel_probe,
   input  logic                  sel_param,
   input  logic                  sel_id,
   input  logic [IDX_W-1:0]      idx,
   input  logic [7:0]            rdata,
   output logic                  sig_ok,
   output logic [8*ID_BYTES-1:0] dev_id,
   output logic [7:0]            feat
);

   localparam int FEAT_IDX = 6;

   if (ID_BYTES < 5) begin : g_bad_id
      $error("nds_capture: ID_BYTES must cover byte 4");
   end
   if (PP_BYTES < FEAT_IDX + 1) begin : g_bad_pp
      $error("nds_capture: PP_BYTES must cover the feature byte");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) sig_ok <= 1'b0;
      else if (take && sel_probe)
         sig_ok <= ((idx == '0) ? 1'b1 : sig_ok) && (rdata == sig_byte(idx[1:0]));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) feat <= '0;
      else if (take && sel_param && idx == IDX_W'(FEAT_IDX)) feat <= rdata;
   end

   for (genvar i = 0; i < ID_BYTES; i++) begin : g_id
      always_ff @(posedge clk) begin
         if (!rst_n) dev_id[8*i +: 8] <= '0;
         else if (take && sel_id && idx == IDX_W'(i)) dev_id[8*i +: 8] <= rdata;
      end
   end

   // R4
   sig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(take && sel_probe) |=> $stable(sig_ok));

endmodule

// File: rtl/nand_discovery_seq.sv
module nand_discovery_seq
   import nds_pkg::*;
#(
   parameter int TMO_CYCLES = 4096,
   parameter int ID_BYTES   = 5,
   parameter int PP_BYTES   = 7
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  strap_no_init,
   input  logic                  strap_small_pg,
   input  logic                  strap_small_x16,
   input  logic                  strap_row2,
   input  logic                  strap_no_preload,
   input  logic                  rb_ready,
   output logic                  bus_req,
   output logic [1:0]            bus_op,
   output logic [7:0]            bus_wdata,
   input  logic                  bus_ack,
   input  logic [7:0]            bus_rdata,
   output logic                  init_done,
   output logic                  tmo_err,
   output logic                  dev_onfi,
   output logic                  dev_x16,
   output logic [8*ID_BYTES-1:0] dev_id,
   output logic [7:0]            onfi_feat
);

   localparam int MAXB    = (PP_BYTES > ID_BYTES) ? PP_BYTES : ID_BYTES;
   localparam int IDX_W   = $clog2(MAXB + 1);
   localparam int WID_BIT = 4*8 + 6;

   seq_state_e       st, st_n;
   logic [IDX_W-1:0] idx;
   straps_t          straps_raw, straps;
   logic             fire, is_wait, rb_ok, tmo_exp, sig_ok;
   logic [IDX_W-1:0] addr_last;
   bus_op_e          op_e;

   assign straps_raw = {strap_no_init, strap_small_pg, strap_small_x16,
                        strap_row2, strap_no_preload};

   nds_strap_latch u_straps (
      .clk(clk), .rst_n(rst_n), .capture(st == ST_STRAP),
      .raw(straps_raw), .q(straps)
   );

   nds_rb_timer #(.TMO_CYCLES(TMO_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .en(is_wait), .rb_ready(rb_ready),
      .ok(rb_ok), .expired(tmo_exp)
   );

   nds_capture #(.ID_BYTES(ID_BYTES), .PP_BYTES(PP_BYTES), .IDX_W(IDX_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .take(fire && op_e == OP_READ),
      .sel_probe(st == ST_PID_R), .sel_param(st == ST_PP_R), .sel_id(st == ST_LI_R),
      .idx(idx), .rdata(bus_rdata), .sig_ok(sig_ok), .dev_id(dev_id), .feat(onfi_feat)
   );

   // column cycles plus row cycles, minus one
   assign addr_last = IDX_W'((straps.small_pg ? 1 : 2) + (straps.row2 ? 2 : 3) - 1);

   always_comb begin
      bus_req   = 1'b0;
      op_e      = OP_CMD;
      bus_wdata = 8'h00;
      is_wait   = 1'b0;
      unique case (st)
         ST_PID_C:  begin bus_req = 1'b1; bus_wdata = CMD_READID; end
         ST_PID_A:  begin bus_req = 1'b1; op_e = OP_ADDR; bus_wdata = ADR_PROBE; end
         ST_PID_R:  begin bus_req = 1'b1; op_e = OP_READ; end
         ST_PP_C:   begin bus_req = 1'b1; bus_wdata = CMD_PARAM; end
         ST_PP_A:   begin bus_req = 1'b1; op_e = OP_ADDR; bus_wdata = ADR_ZERO; end
         ST_PP_R:   begin bus_req = 1'b1; op_e = OP_READ; end
         ST_LR_C:   begin bus_req = 1'b1; bus_wdata = CMD_RESET; end
         ST_LI_C:   begin bus_req = 1'b1; bus_wdata = CMD_READID; end
         ST_LI_A:   begin bus_req = 1'b1; op_e = OP_ADDR; bus_wdata = ADR_ZERO; end
         ST_LI_R:   begin bus_req = 1'b1; op_e = OP_READ; end
         ST_WR_C:   begin bus_req = 1'b1; bus_wdata = CMD_RESET; end
         ST_PL_C0:  begin bus_req = 1'b1; bus_wdata = CMD_PGRD1; end
         ST_PL_A:   begin bus_req = 1'b1; op_e = OP_ADDR; bus_wdata = ADR_ZERO; end
         ST_PL_C1:  begin bus_req = 1'b1; bus_wdata = CMD_PGRD2; end
         ST_FR_C:   begin bus_req = 1'b1; bus_wdata = CMD_RESET; end
         ST_RB0, ST_PP_W, ST_LR_W, ST_WR_W, ST_PL_W, ST_FR_W: is_wait = 1'b1;
         default: ;
      endcase
   end

   assign bus_op    = op_e;
   assign fire      = bus_req && bus_ack;
   assign init_done = (st == ST_DONE);

   always_comb begin
      st_n = st;
      unique case (st)
         ST_STRAP: st_n = strap_no_init ? ST_FR_C : ST_RB0;
         ST_RB0: begin
            if (rb_ok)        st_n = straps.small_pg ? ST_LR_C : ST_PID_C;
            else if (tmo_exp) st_n = ST_FR_C;
         end
         ST_PID_C: if (fire) st_n = ST_PID_A;
         ST_PID_A: if (fire) st_n = ST_PID_R;
         ST_PID_R: if (fire && idx == IDX_W'(3)) st_n = ST_PID_D;
         ST_PID_D: st_n = sig_ok ? ST_PP_C : ST_LR_C;
         ST_PP_C:  if (fire) st_n = ST_PP_A;
         ST_PP_A:  if (fire) st_n = ST_PP_W;
         ST_PP_W: begin
            if (rb_ok)        st_n = ST_PP_R;
            else if (tmo_exp) st_n = ST_FR_C;
         end
         ST_PP_R:  if (fire && idx == IDX_W'(PP_BYTES - 1)) st_n = ST_WR_C;
         ST_LR_C:  if (fire) st_n = ST_LR_W;
         ST_LR_W: begin
            if (rb_ok)        st_n = ST_LI_C;
            else if (tmo_exp) st_n = ST_FR_C;
         end
         ST_LI_C:  if (fire) st_n = ST_LI_A;
         ST_LI_A:  if (fire) st_n = ST_LI_R;
         ST_LI_R:  if (fire && idx == IDX_W'(ID_BYTES - 1)) st_n = ST_WR_C;
         ST_WR_C:  if (fire) st_n = ST_WR_W;
         ST_WR_W: begin
            if (rb_ok)        st_n = straps.no_preload ? ST_FR_C : ST_PL_C0;
            else if (tmo_exp) st_n = ST_FR_C;
         end
         ST_PL_C0: if (fire) st_n = ST_PL_A;
         ST_PL_A:  if (fire && idx == addr_last) st_n = ST_PL_C1;
         ST_PL_C1: if (fire) st_n = ST_PL_W;
         ST_PL_W:  if (rb_ok || tmo_exp) st_n = ST_FR_C;
         ST_FR_C:  if (fire) st_n = ST_FR_W;
         ST_FR_W:  if (rb_ok || tmo_exp) st_n = ST_DONE;
         default:  st_n = ST_DONE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_STRAP;
         idx      <= '0;
         tmo_err  <= 1'b0;
         dev_onfi <= 1'b0;
         dev_x16  <= 1'b0;
      end else begin
         st <= st_n;
         if (st_n != st) idx <= '0;
         else if (fire)  idx <= idx + 1'b1;
         if (tmo_exp) tmo_err <= 1'b1;
         if (st == ST_PID_D && sig_ok) dev_onfi <= 1'b1;
         if (st == ST_WR_C && fire)
            dev_x16 <= straps.small_x16 ||
                       (dev_onfi ? onfi_feat[0] : dev_id[WID_BIT]);
      end
   end

   // R11
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack) |=> bus_req && $stable(bus_op) && $stable(bus_wdata));

   // R3
   rb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RB0 && !rb_ready && !tmo_exp) |=> !bus_req);

   // R9
   done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> init_done && !bus_req);

   // R10
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_err |=> tmo_err);

   // R10
   tmo_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_exp |=> (st == ST_FR_C || st == ST_DONE));

endmodule

// File: tb/nand_discovery_seq_tb.sv
module nand_discovery_seq_tb;

   localparam int CLK_PERIOD = 10;
   localparam int TMO        = 40;
   localparam int BUSY       = 6;
   localparam int INIT_BUSY  = 12;
   localparam int NV         = 8;

   // {no_init, small_pg, small_x16, row2, no_preload, onfi_dev, slow, feat[7:0], id4[7:0]}
   localparam logic [22:0] VEC [NV] = '{
      {1'b0,1'b0,1'b0,1'b0,1'b1, 1'b1,1'b0, 8'h18, 8'h00},
      {1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b1, 8'h19, 8'h00},
      {1'b0,1'b0,1'b0,1'b1,1'b0, 1'b0,1'b0, 8'h00, 8'h40},
      {1'b0,1'b0,1'b0,1'b0,1'b1, 1'b0,1'b1, 8'h00, 8'hBF},
      {1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0, 8'h01, 8'h40},
      {1'b0,1'b1,1'b1,1'b1,1'b0, 1'b0,1'b1, 8'h00, 8'h00},
      {1'b0,1'b0,1'b1,1'b0,1'b1, 1'b1,1'b0, 8'h00, 8'h00},
      {1'b0,1'b1,1'b0,1'b0,1'b1, 1'b1,1'b0, 8'h00, 8'h00}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        s_ni = 1'b0, s_sp = 1'b0, s_sx = 1'b0, s_r2 = 1'b0, s_np = 1'b1;
   logic        rb_ready, bus_req, bus_ack, init_done, tmo_err, dev_onfi, dev_x16;
   logic [1:0]  bus_op;
   logic [7:0]  bus_wdata, bus_rdata, onfi_feat;
   logic [39:0] dev_id;

   int total = 0;
   int bad   = 0;

   // device model state
   logic [7:0] m_cmd, m_addr, m_feat = 8'h00, m_id4 = 8'h00;
   int         m_rptr, m_busy;
   logic       m_dead = 1'b0, m_stuck_mode = 1'b0, m_stuck, m_onfi = 1'b0;
   logic       slow = 1'b0, phase;

   logic [9:0] tlog [32];
   int         tlen;
   logic [9:0] ex [32];
   int         elen;
   logic       ready_seen, early_req;

   nand_discovery_seq #(.TMO_CYCLES(TMO)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .strap_no_init(s_ni), .strap_small_pg(s_sp), .strap_small_x16(s_sx),
      .strap_row2(s_r2), .strap_no_preload(s_np),
      .rb_ready(rb_ready), .bus_req(bus_req), .bus_op(bus_op), .bus_wdata(bus_wdata),
      .bus_ack(bus_ack), .bus_rdata(bus_rdata), .init_done(init_done), .tmo_err(tmo_err),
      .dev_onfi(dev_onfi), .dev_x16(dev_x16), .dev_id(dev_id), .onfi_feat(onfi_feat)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [7:0] id_b(input int i, input logic [7:0] b4);
      case (i)
         0: return 8'h2C;
         1: return 8'hDA;
         2: return 8'h90;
         3: return 8'h95;
         4: return b4;
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic [7:0] pp_b(input int i, input logic [7:0] f);
      case (i)
         0: return 8'h4F;
         1: return 8'h4E;
         2: return 8'h46;
         3: return 8'h49;
         4: return 8'h02;
         6: return f;
         default: return 8'h00;
      endcase
   endfunction

   always_comb begin
      bus_rdata = 8'h00;
      if (m_cmd == 8'h90)
         bus_rdata = (m_addr == 8'h20 && m_onfi) ? pp_b(m_rptr, m_feat) : id_b(m_rptr, m_id4);
      else if (m_cmd == 8'hEC)
         bus_rdata = pp_b(m_rptr, m_feat);
   end

   assign rb_ready = (m_busy == 0) && !m_dead && !m_stuck;
   assign bus_ack  = bus_req && (!slow || phase);

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cmd <= 8'h00; m_addr <= 8'h00; m_rptr <= 0; m_busy <= INIT_BUSY;
         m_stuck <= 1'b0; phase <= 1'b0; tlen <= 0;
      end else begin
         phase <= ~phase;
         if (m_busy != 0) m_busy <= m_busy - 1;
         if (bus_req && bus_ack) begin
            if (bus_op != 2'd2 && tlen < 32) begin
               tlog[tlen] <= {bus_op, bus_wdata};
               tlen <= tlen + 1;
            end
            case (bus_op)
               2'd0: begin
                  m_cmd <= bus_wdata; m_rptr <= 0;
                  if (bus_wdata == 8'hFF || bus_wdata == 8'hEC || bus_wdata == 8'h30)
                     m_busy <= BUSY;
                  if (bus_wdata == 8'hEC && m_stuck_mode) m_stuck <= 1'b1;
               end
               2'd1: m_addr <= bus_wdata;
               default: m_rptr <= m_rptr + 1;
            endcase
         end
      end
   end

   always @(negedge clk) begin
      if (!rst_n) begin
         ready_seen = 1'b0; early_req = 1'b0;
      end else begin
         if (bus_req && !ready_seen) early_req = 1'b1;
         if (rb_ready) ready_seen = 1'b1;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic push(input logic [1:0] op, input logic [7:0] b);
      ex[elen] = {op, b};
      elen++;
   endtask

   task automatic start(input logic [22:0] v, input bit dead, input bit stuck);
      {s_ni, s_sp, s_sx, s_r2, s_np} = v[22:18];
      m_onfi = v[17]; slow = v[16]; m_feat = v[15:8]; m_id4 = v[7:0];
      m_dead = dead; m_stuck_mode = stuck;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: every strap flipped after the capture edge
      {s_ni, s_sp, s_sx, s_r2, s_np} = ~v[22:18];
      for (int c = 0; c < 5000 && !init_done; c++) @(negedge clk);
   endtask

   task automatic cmp_log(input string req);
      bit same = (tlen == elen);
      chk(tlen == elen, req, 64'(tlen), 64'(elen));
      for (int k = 0; k < 32; k++)
         if (k < elen && k < tlen && tlog[k] != ex[k]) same = 1'b0;
      chk(same, req, 64'(tlog[0]), 64'(ex[0]));
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R12: reset state
      repeat (3) @(negedge clk);
      chk({bus_req, init_done, tmo_err, dev_onfi, dev_x16} == 5'b0, "R12",
          64'({bus_req, init_done, tmo_err, dev_onfi, dev_x16}), 64'd0);

      for (int n = 0; n < NV; n++) begin
         logic [22:0] v = VEC[n];
         bit ni = v[22], sp = v[21], sx = v[20], r2 = v[19], np = v[18], od = v[17];
         bit e_onfi = !ni && !sp && od;
         bit e_leg  = !ni && !e_onfi;
         bit e_x16  = !ni && (sx || (e_onfi ? v[8] : v[6]));
         logic [39:0] e_id = e_leg ? {v[7:0], 8'h95, 8'h90, 8'hDA, 8'h2C} : 40'd0;
         logic [7:0]  e_ft = e_onfi ? v[15:8] : 8'h00;
         start(v, 1'b0, 1'b0);
         elen = 0;
         if (!ni) begin
            if (!sp) begin push(2'd0, 8'h90); push(2'd1, 8'h20); end
            if (e_onfi) begin push(2'd0, 8'hEC); push(2'd1, 8'h00); end
            else begin push(2'd0, 8'hFF); push(2'd0, 8'h90); push(2'd1, 8'h00); end
            push(2'd0, 8'hFF);
            if (!np) begin
               push(2'd0, 8'h00);
               for (int a = 0; a < (sp ? 1 : 2) + (r2 ? 2 : 3); a++) push(2'd1, 8'h00);
               push(2'd0, 8'h30);
            end
         end
         push(2'd0, 8'hFF);
         // R9 R2 R4 R5 R6 R8 R11 transcript
         cmp_log(ni ? "R2" : (sp ? "R6" : (np ? "R4" : "R8")));
         chk(init_done, "R9", 64'(init_done), 64'd1);
         chk(!tmo_err, "R10", 64'(tmo_err), 64'd0);
         chk(dev_onfi == e_onfi, "R4", 64'(dev_onfi), 64'(e_onfi));
         chk(dev_x16 == e_x16, "R7", 64'(dev_x16), 64'(e_x16));
         chk(dev_id == e_id, "R5", 64'(dev_id), 64'(e_id));
         chk(onfi_feat == e_ft, "R4", 64'(onfi_feat), 64'(e_ft));
         if (!ni) chk(!early_req, "R3", 64'(early_req), 64'd0);
      end

      // R9: completion holds, nothing more requested
      repeat (20) @(negedge clk);
      chk(init_done && !bus_req, "R9", 64'({init_done, bus_req}), 64'b10);

      // R10: dead device, both waits time out
      start(VEC[0], 1'b1, 1'b0);
      elen = 0; push(2'd0, 8'hFF);
      cmp_log("R10");
      chk(tmo_err && init_done, "R10", 64'({tmo_err, init_done}), 64'b11);
      chk(!dev_onfi && !dev_x16, "R10", 64'({dev_onfi, dev_x16}), 64'd0);

      // R10: stall after parameter-page command
      start(VEC[0], 1'b0, 1'b1);
      elen = 0;
      push(2'd0, 8'h90); push(2'd1, 8'h20); push(2'd0, 8'hEC); push(2'd1, 8'h00);
      push(2'd0, 8'hFF);
      cmp_log("R10");
      chk(tmo_err && init_done && dev_onfi, "R10",
          64'({tmo_err, init_done, dev_onfi}), 64'b111);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule